// File: doc/BRIEF.md
# SMBus Control and Interrupt Sequencer

This block is the control and status core of an SMBus master/slave interface. Software writes a control word. That word can ask for a START, ask for a STOP, set the outgoing acknowledge value, or release the interrupt flag. The block turns those requests into single-cycle START and STOP generation pulses for the bit-level engine. It keeps the master and transmit-mode bits, an arbitration-lost flag, a slave bus-error flag and the interrupt flag.

The interrupt flag gates the whole bus. While it is set, the block asks the pin logic to keep SCL low, so nothing moves until software clears the flag. Other logic reports bus-free, detected START and STOP conditions, byte-frame completion, the end of each ACK cycle and arbitration loss. The block folds these into the flag and into an eight-bit status vector. The upper nibble of that vector is the vector that service code dispatches on.

A START request is sticky: the hardware never withdraws it. A STOP request waits for the next ACK cycle. When both are pending, the STOP goes out first and the START follows once the flag is released and the bus is free.

Top module: `smb_ctl_seq`

## Requirements
- R1: After reset every status bit is 0, `scl_hold` is 0, `ack_out` is 0 and neither generation pulse is asserted.
- R2: A write with bit 5 set asks for a START. When the block is not master, the interrupt flag is clear and `bus_free` is high at a clock edge, `gen_start` pulses for exactly one cycle after that edge. In that same cycle, master (status bit 7), transmit mode (bit 6), the START report (bit 5) and the interrupt flag (bit 0) all read 1.
- R3: No START is generated while `bus_free` is low.
- R4: Issuing a START does not clear the START request. Status bit 5 stays 1 until software writes bit 5 as 0.
- R5: A write with bit 4 set asks for a STOP. In master mode, `gen_stop` pulses one cycle after an edge where `ack_done` is high; in that cycle master reads 0 and the interrupt flag reads 1. Outside master mode, a STOP request generates no STOP.
- R6: With both requests pending in master mode, the STOP is generated first. The START follows only after the interrupt flag has been cleared and the bus is free. The two pulses are never asserted together.
- R7: The interrupt flag is set by a completed byte frame, by a generated START, by a generated STOP and by qualifying arbitration loss.
- R8: `scl_hold` is high exactly while the interrupt flag is set. A write with bit 0 set leaves the flag unchanged.
- R9: A write with bit 0 at 0 while the flag is set clears the flag. The same write also clears arbitration-lost (bit 1), bus-error (bit 2) and the START/STOP reports that came from detected or generated conditions.
- R10: `arb_lost` counts only while transmit mode is 1. When it counts, it sets bit 1 and the flag, and it drops master mode. If it happens while the block is a slave, it also sets bus-error bit 2.
- R11: A single write can set the acknowledge value (bit 3) and clear the flag. One cycle after that write, `ack_out` shows the new value and `scl_hold` is low.
- R12: A detected STOP clears master mode and sets status bit 4. A detected START sets status bit 5. Neither one generates a condition.
- R13: A byte-frame completion loads transmit mode from `xfer_tx`.
- R14: If a flag-setting event arrives in the same cycle as a clearing write, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word: bit 5 START request, bit 4 STOP request, bit 3 ACK value, bit 0 flag (0 clears) |
| bus_free | input | 1 | Bus is idle |
| det_start | input | 1 | START condition seen on the bus |
| det_stop | input | 1 | STOP condition seen on the bus |
| byte_done | input | 1 | Byte frame completed |
| xfer_tx | input | 1 | Direction of the frame just completed (1 = transmit) |
| ack_done | input | 1 | ACK cycle ended |
| arb_lost | input | 1 | Arbitration loss from the bit engine |
| gen_start | output | 1 | One-cycle request to generate a START |
| gen_stop | output | 1 | One-cycle request to generate a STOP |
| scl_hold | output | 1 | Keep SCL low |
| ack_out | output | 1 | Outgoing acknowledge value |
| status | output | 8 | {master, txmode, sta, sto, ack, bus_err, arb_lost, flag} |

## Verification
The block has no size parameters. All field positions come from package constants, so the bench builds the one default configuration. A directed prologue exercises the issue gating on `bus_free` and the interrupt flag, the STOP-after-ACK ordering with both requests pending, slave arbitration loss, and a flag clear that collides with a new event. Several thousand seeded random cycles then mix writes with bus events. That makes it possible to reach overlapping START/STOP requests, detected conditions in master mode, and arbitration loss at random points in a transfer.

// File: rtl/smb_ctl_pkg.sv
package smb_ctl_pkg;

    localparam int REG_W = 8;

    // control word / status vector bit positions
    localparam int B_FLAG   = 0;
    localparam int B_ARB    = 1;
    localparam int B_BERR   = 2;
    localparam int B_ACK    = 3;
    localparam int B_STO    = 4;
    localparam int B_STA    = 5;
    localparam int B_TX     = 6;
    localparam int B_MASTER = 7;

    typedef struct packed {
        logic master;
        logic txmode;
        logic sta_req;
        logic sto_req;
        logic sta_seen;
        logic sto_seen;
        logic ack;
        logic flag;
        logic arb;
        logic berr;
        logic gen_start;
        logic gen_stop;
    } ctl_state_t;

endpackage

// File: rtl/smb_req_seq.sv
module smb_req_seq (
    input  logic sta_req,
    input  logic sto_req,
    input  logic master,
    input  logic flag,
    input  logic bus_free,
    input  logic ack_done,
    output logic issue_start,
    output logic issue_stop
);
    // START: only from slave state, only when the bus is idle and not stalled
    always_comb begin
        issue_start = sta_req && !master && bus_free && !flag;
        issue_stop  = sto_req && master && ack_done;
    end
endmodule

// File: rtl/smb_evt_qual.sv
module smb_evt_qual (
    input  logic wr_en,
    input  logic wr_flag,
    input  logic flag,
    input  logic arb_lost,
    input  logic txmode,
    input  logic master,
    output logic flag_clr,
    output logic arb_hit,
    output logic arb_slave
);
    always_comb begin
        flag_clr  = wr_en && !wr_flag && flag;
        arb_hit   = arb_lost && txmode;
        arb_slave = arb_hit && !master;
    end
endmodule

// File: rtl/smb_ctl_seq.sv
module smb_ctl_seq
    import smb_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             bus_free,
    input  logic             det_start,
    input  logic             det_stop,
    input  logic             byte_done,
    input  logic             xfer_tx,
    input  logic             ack_done,
    input  logic             arb_lost,
    output logic             gen_start,
    output logic             gen_stop,
    output logic             scl_hold,
    output logic             ack_out,
    output logic [REG_W-1:0] status
);

    ctl_state_t st_d, st_q;
    logic issue_start, issue_stop;
    logic flag_clr, arb_hit, arb_slave;

    smb_req_seq u_req (
        .sta_req     (st_q.sta_req),
        .sto_req     (st_q.sto_req),
        .master      (st_q.master),
        .flag        (st_q.flag),
        .bus_free    (bus_free),
        .ack_done    (ack_done),
        .issue_start (issue_start),
        .issue_stop  (issue_stop)
    );

    smb_evt_qual u_qual (
        .wr_en     (wr_en),
        .wr_flag   (wr_data[B_FLAG]),
        .flag      (st_q.flag),
        .arb_lost  (arb_lost),
        .txmode    (st_q.txmode),
        .master    (st_q.master),
        .flag_clr  (flag_clr),
        .arb_hit   (arb_hit),
        .arb_slave (arb_slave)
    );

    always_comb begin
        st_d           = st_q;
        st_d.gen_start = 1'b0;
        st_d.gen_stop  = 1'b0;

        // software write: requests and ack value follow the written word
        if (wr_en) begin
            st_d.sta_req = wr_data[B_STA];
            st_d.sto_req = wr_data[B_STO];
            st_d.ack     = wr_data[B_ACK];
        end

        // flag release wipes the per-interrupt reports
        if (flag_clr) begin
            st_d.flag     = 1'b0;
            st_d.arb      = 1'b0;
            st_d.berr     = 1'b0;
            st_d.sta_seen = 1'b0;
            st_d.sto_seen = 1'b0;
        end

        // conditions observed on the bus
        if (det_start) st_d.sta_seen = 1'b1;
        if (det_stop) begin
            st_d.sto_seen = 1'b1;
            st_d.master   = 1'b0;
        end

        if (byte_done) begin
            st_d.flag   = 1'b1;
            st_d.txmode = xfer_tx;
        end

        if (issue_start) begin
            st_d.master    = 1'b1;
            st_d.txmode    = 1'b1;
            st_d.sta_seen  = 1'b1;
            st_d.flag      = 1'b1;
            st_d.gen_start = 1'b1;
        end

        if (issue_stop) begin
            st_d.master   = 1'b0;
            st_d.sto_req  = 1'b0;
            st_d.sto_seen = 1'b1;
            st_d.flag     = 1'b1;
            st_d.gen_stop = 1'b1;
        end

        if (arb_hit) begin
            st_d.arb    = 1'b1;
            st_d.flag   = 1'b1;
            st_d.master = 1'b0;
            if (arb_slave) st_d.berr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gen_start = st_q.gen_start;
    assign gen_stop  = st_q.gen_stop;
    assign scl_hold  = st_q.flag;
    assign ack_out   = st_q.ack;

    always_comb begin
        status           = '0;
        status[B_MASTER] = st_q.master;
        status[B_TX]     = st_q.txmode;
        status[B_STA]    = st_q.sta_req | st_q.sta_seen;
        status[B_STO]    = st_q.sto_req | st_q.sto_seen;
        status[B_ACK]    = st_q.ack;
        status[B_BERR]   = st_q.berr;
        status[B_ARB]    = st_q.arb;
        status[B_FLAG]   = st_q.flag;
    end

endmodule

// File: rtl/smb_ctl_seq_chk.sv
module smb_ctl_seq_chk
    import smb_ctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic             bus_free,
    input logic             ack_done,
    input logic             arb_lost,
    input logic             byte_done,
    input logic             gen_start,
    input logic             gen_stop,
    input logic             scl_hold,
    input logic [REG_W-1:0] status
);
    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_start |=> !gen_start);

    // R3
    start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_start |-> $past(bus_free));

    // R5
    stop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_stop |-> ($past(ack_done) && $past(status[B_MASTER])));

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gen_start && gen_stop));

    // R8
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_FLAG] && !(wr_en && !wr_data[B_FLAG])) |=> status[B_FLAG]);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_hold) |-> (!status[B_ARB] && !status[B_BERR]));

    // R10
    arb_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[B_ARB]) |-> $past(arb_lost && status[B_TX]));

    // R7
    byte_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> scl_hold);
endmodule

bind smb_ctl_seq smb_ctl_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .bus_free  (bus_free),
    .ack_done  (ack_done),
    .arb_lost  (arb_lost),
    .byte_done (byte_done),
    .gen_start (gen_start),
    .gen_stop  (gen_stop),
    .scl_hold  (scl_hold),
    .status    (status)
);

// File: tb/smb_ctl_seq_tb.sv
module smb_ctl_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 4000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       bus_free = 1'b0, det_start = 1'b0, det_stop = 1'b0;
    logic       byte_done = 1'b0, xfer_tx = 1'b0, ack_done = 1'b0, arb_lost = 1'b0;
    logic       gen_start, gen_stop, scl_hold, ack_out;
    logic [7:0] status;

    int n_checks = 0;
    int n_fail   = 0;

    // reference state
    bit m_master, m_tx, m_sta, m_sto, m_ssta, m_ssto, m_ack, m_flag, m_arb, m_berr, m_gs, m_gp;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_ctl_seq dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .bus_free(bus_free), .det_start(det_start), .det_stop(det_stop),
        .byte_done(byte_done), .xfer_tx(xfer_tx), .ack_done(ack_done),
        .arb_lost(arb_lost), .gen_start(gen_start), .gen_stop(gen_stop),
        .scl_hold(scl_hold), .ack_out(ack_out), .status(status)
    );

    function automatic logic [7:0] exp_status();
        return {m_master, m_tx, m_sta | m_ssta, m_sto | m_ssto, m_ack, m_berr, m_arb, m_flag};
    endfunction

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        {m_master, m_tx, m_sta, m_sto, m_ssta, m_ssto, m_ack, m_flag, m_arb, m_berr, m_gs, m_gp} = '0;
    endtask

    task automatic model_step();
        bit clr, is, ip, arb, om;
        om  = m_master;
        clr = wr_en && !wr_data[0] && m_flag;
        is  = m_sta && !m_master && bus_free && !m_flag;
        ip  = m_sto && m_master && ack_done;
        arb = arb_lost && m_tx;
        m_gs = 0; m_gp = 0;
        if (wr_en) begin m_sta = wr_data[5]; m_sto = wr_data[4]; m_ack = wr_data[3]; end
        if (clr) begin m_flag = 0; m_arb = 0; m_berr = 0; m_ssta = 0; m_ssto = 0; end
        if (det_start) m_ssta = 1;
        if (det_stop) begin m_ssto = 1; m_master = 0; end
        if (byte_done) begin m_flag = 1; m_tx = xfer_tx; end
        if (is) begin m_master = 1; m_tx = 1; m_ssta = 1; m_flag = 1; m_gs = 1; end
        if (ip) begin m_master = 0; m_sto = 0; m_ssto = 1; m_flag = 1; m_gp = 1; end
        if (arb) begin m_arb = 1; m_flag = 1; m_master = 0; if (!om) m_berr = 1; end
    endtask

    task automatic compare(input string req);
        logic [7:0] e;
        e = exp_status();
        check(status === e, req, status, e);
        check(gen_start === m_gs && gen_stop === m_gp, {req, " pulses"},
              {6'b0, gen_start, gen_stop}, {6'b0, m_gs, m_gp});
        check(scl_hold === m_flag && ack_out === m_ack, {req, " hold/ack"},
              {6'b0, scl_hold, ack_out}, {6'b0, m_flag, m_ack});
    endtask

    task automatic quiet();
        wr_en = 0; det_start = 0; det_stop = 0; byte_done = 0; ack_done = 0; arb_lost = 0;
    endtask

    // one clock: inputs already set; update model at edge, compare at falling edge
    task automatic step(input string req);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(req);
        quiet();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", n_checks, 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0017));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(status === 8'h00 && !scl_hold && !ack_out && !gen_start && !gen_stop,
              "R1 reset", status, 8'h00);

        // R3: start request while bus busy
        wr_en = 1; wr_data = 8'h20; bus_free = 0;
        step("R3 request");
        repeat (3) step("R3 busy");
        check(gen_start === 1'b0, "R3 no start while busy", {7'b0, gen_start}, 8'h00);
        // R2: bus becomes free
        bus_free = 1;
        step("R2 issue");
        check(gen_start === 1'b1 && status[7] && status[6] && status[5] && status[0],
              "R2 start pulse", status, 8'he1);
        bus_free = 0;
        step("R2 pulse end");
        check(gen_start === 1'b0, "R2 single pulse", {7'b0, gen_start}, 8'h00);
        // R4 request still set
        check(status[5] === 1'b1, "R4 sta sticky", status, 8'he1);

        // R8: write with flag bit 1 leaves flag set
        wr_en = 1; wr_data = 8'h21;
        step("R8 write ones");
        check(scl_hold === 1'b1, "R8 flag kept", {7'b0, scl_hold}, 8'h01);

        // R13: byte frame loads receive direction
        wr_en = 1; wr_data = 8'h00;
        step("R9 clear");
        byte_done = 1; xfer_tx = 0;
        step("R13 rx byte");
        check(status[6] === 1'b0 && scl_hold, "R13 txmode from frame", status, 8'h81);

        // R11 + R5: clear flag with ack=1, request stop
        wr_en = 1; wr_data = 8'h18;
        step("R11 ack+release");
        check(ack_out === 1'b1 && scl_hold === 1'b0, "R11 ack with release",
              {6'b0, ack_out, scl_hold}, 8'h02);
        ack_done = 1;
        step("R5 stop");
        check(gen_stop === 1'b1 && !status[7] && status[0], "R5 stop after ack", status, 8'h19);

        // R5: stop request as slave generates nothing
        wr_en = 1; wr_data = 8'h10;
        step("R5 slave req");
        ack_done = 1;
        step("R5 slave ack");
        check(gen_stop === 1'b0, "R5 no stop as slave", {7'b0, gen_stop}, 8'h00);

        // R6: both requests in master mode
        wr_en = 1; wr_data = 8'h20; bus_free = 1;
        step("R6 sta");
        step("R6 start");
        check(status[7] === 1'b1, "R6 master", status, 8'he1);
        wr_en = 1; wr_data = 8'h30;
        step("R6 both");
        ack_done = 1;
        step("R6 stop first");
        check(gen_stop === 1'b1 && gen_start === 1'b0, "R6 stop before start",
              {6'b0, gen_start, gen_stop}, 8'h01);
        step("R6 stalled");
        check(gen_start === 1'b0, "R6 no start while flag set", {7'b0, gen_start}, 8'h00);
        wr_en = 1; wr_data = 8'h20;
        step("R6 release");
        step("R6 restart");
        check(gen_start === 1'b1, "R6 start follows", {7'b0, gen_start}, 8'h01);

        // R12: detected stop in master mode
        wr_en = 1; wr_data = 8'h00;
        step("R12 release");
        det_stop = 1;
        step("R12 det stop");
        check(status[7] === 1'b0 && status[4] === 1'b1 && gen_stop === 1'b0,
              "R12 master cleared", status, 8'h50);
        det_start = 1;
        step("R12 det start");
        check(status[5] === 1'b1 && gen_start === 1'b0, "R12 sta report", status, 8'h70);

        // R10: slave arbitration loss while transmitting
        byte_done = 1; xfer_tx = 1;
        step("R10 tx frame");
        wr_en = 1; wr_data = 8'h00;
        step("R10 release");
        arb_lost = 1;
        step("R10 arb");
        check(status[1] && status[2] && status[0], "R10 slave arb err", status, 8'h47);
        // R9: release clears both
        wr_en = 1; wr_data = 8'h00;
        step("R9 release");
        check(!status[1] && !status[2] && !status[0], "R9 cleared", status, 8'h40);

        // R10: arb loss ignored in receive mode
        byte_done = 1; xfer_tx = 0;
        step("R10 rx frame");
        wr_en = 1; wr_data = 8'h00;
        step("R10 release2");
        arb_lost = 1;
        step("R10 ignored");
        check(status[1] === 1'b0 && scl_hold === 1'b0, "R10 no arb in rx", status, 8'h00);

        // R14: event collides with release
        byte_done = 1;
        step("R14 set");
        wr_en = 1; wr_data = 8'h00; byte_done = 1;
        step("R14 collide");
        check(scl_hold === 1'b1, "R14 event wins", {7'b0, scl_hold}, 8'h01);

        // R7 random mix
        for (int i = 0; i < N_RAND; i++) begin
            wr_en     = ($urandom % 6) == 0;
            wr_data   = 8'($urandom) & 8'h39;
            bus_free  = $urandom % 2;
            det_start = ($urandom % 20) == 0;
            det_stop  = ($urandom % 20) == 0;
            byte_done = ($urandom % 10) == 0;
            xfer_tx   = $urandom % 2;
            ack_done  = ($urandom % 8) == 0;
            arb_lost  = ($urandom % 25) == 0;
            step("R7 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule